// File: doc/BRIEF.md
# Serial Flash Master with Byte FIFOs

This block is a serial-peripheral master for driving a serial flash chip under software control. A 32-bit register port pushes outgoing bytes into an 8-entry transmit queue and pops returned bytes from an 8-entry receive queue. A shifter takes one byte at a time from the transmit queue and clocks it out as one frame. It drives the serial clock, one active-low chip select and up to four data lanes, and it captures the data that comes back.

Software sets the clock rate and the clock polarity and phase. It also sets the frame format: one, two or four lanes, bit order, direction and frame length. The chip-select policy covers three cases: a select per frame, a select held across many frames (so that a command byte, its echo and any number of status polls share one select), and no select at all. The transmit direction makes the shifter drop captured data, so a long command does not fill the receive queue. Queue status is carried in bit 31 of the two data registers, and two watermark flags can raise an interrupt.

The register port is a plain read/write strobe pair. Data moves through the queues with internal valid/ready handshakes. A byte written to a full transmit queue finds no ready and is lost. A read of an empty receive queue finds no valid, pops nothing, and reports empty. The shifter itself never stalls: a byte received while the receive queue is full is dropped.

Top module: `spif_ctrl`

## Requirements
- R1: After reset the divider register (0x00) reads 3, `cs_n` is 1, `sck` is 0 and `irq` is 0. The SCK period is 2*(div+1) core clocks, and a new divider value takes effect even during a frame.
- R2: Register 0x04 bit 0 sets the SCK idle level (polarity). Bit 1 selects the phase: 0 samples on the leading edge and launches on the trailing edge; 1 launches on the leading edge and samples on the trailing edge.
- R3: Register 0x40 holds the lane mode in bits 1:0 (0 one lane, 1 two lanes, 2 four lanes), the bit order in bit 2 (0 MSB first, 1 LSB first), the direction in bit 3 (0 receive, 1 transmit) and the frame length in bits 19:16. These are latched when a frame starts.
- R4: In one-lane mode data leaves on `dq_o[0]` and returns on `dq_i[1]`. In two- and four-lane modes lanes 1:0 or 3:0 carry both directions, with the higher lane holding the earlier bit. `dq_oe` enables those lanes only in transmit direction.
- R5: Register 0x18 sets the chip-select mode. 0 (auto) asserts `cs_n` low for each frame and releases it between frames. 2 (hold) keeps it low after a frame. 3 (off) never asserts it.
- R6: A write to 0x48 pushes bits 7:0 into the transmit queue. A read of 0x48 returns bit 31 set while the queue holds 8 bytes. A write to a full queue is ignored.
- R7: A read of 0x4C returns bit 31 set when the receive queue is empty and pops nothing. Otherwise it returns bit 31 clear with the oldest byte in bits 7:0 and pops it.
- R8: A frame in transmit direction pushes nothing into the receive queue. A frame in receive direction pushes exactly one byte.
- R9: Register 0x74 bit 0 is set while the transmit count is below the watermark in 0x50 bits 15:0. Bit 1 is set while the receive count is above the watermark in 0x54 bits 15:0.
- R10: `irq` is the OR of the bits that are set in both 0x74 and the enable register 0x70.
- R11: A select held in hold mode is released only after the mode register leaves hold while the shifter is idle. Successive frames in hold mode share one select.
- R12: A frame carries the programmed length (1 to 8 bits; 0 or more than 8 means 8; it must be a multiple of the lane count). In MSB-first order a short frame sends bits len-1..0 of the byte and returns its bits right-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (pops the receive queue at 0x4C) |
| reg_addr | input | 8 | register byte offset |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data, valid in the cycle of `reg_rd` |
| sck | output | 1 | serial clock |
| cs_n | output | 1 | chip select, active low |
| dq_o | output | 4 | data lanes out |
| dq_oe | output | 4 | per-lane output enable |
| dq_i | input | 4 | data lanes in |
| irq | output | 1 | watermark interrupt |

## Verification
The hardest state to reach is a full transmit queue followed by one more write that must be lost. The shifter normally drains the queue as soon as a byte lands. The stimulus therefore slows the divider to 200 so the first frame stalls, fills the queue and overflows it, then drops the divider to 0 mid-frame and counts the select pulses that follow. A second hard case is the held select across a command and two polls. A model of the flash in the bench reloads its reply stream only on a falling select, so any extra release shows up as wrong reply bytes as well as an extra rising edge.

// File: rtl/spif_pkg.sv
package spif_pkg;
  localparam logic [7:0] A_DIV    = 8'h00;
  localparam logic [7:0] A_CLKM   = 8'h04;
  localparam logic [7:0] A_CSMODE = 8'h18;
  localparam logic [7:0] A_FMT    = 8'h40;
  localparam logic [7:0] A_TXD    = 8'h48;
  localparam logic [7:0] A_RXD    = 8'h4C;
  localparam logic [7:0] A_TXCTL  = 8'h50;
  localparam logic [7:0] A_RXCTL  = 8'h54;
  localparam logic [7:0] A_IE     = 8'h70;
  localparam logic [7:0] A_IP     = 8'h74;

  typedef enum logic [1:0] {
    CS_AUTO = 2'd0, CS_RSV = 2'd1, CS_HOLD = 2'd2, CS_OFF = 2'd3
  } cs_mode_e;

  typedef struct packed {
    logic [3:0] len;
    logic       dir_tx;
    logic       lsb_first;
    logic [1:0] proto;
  } fmt_t;

  function automatic logic [2:0] lane_cnt(input logic [1:0] p);
    return (p == 2'd1) ? 3'd2 : (p == 2'd2) ? 3'd4 : 3'd1;
  endfunction

  function automatic logic [1:0] lane_log(input logic [1:0] p);
    return (p == 2'd1) ? 2'd1 : (p == 2'd2) ? 2'd2 : 2'd0;
  endfunction

  function automatic logic [3:0] eff_len(input logic [3:0] l);
    return (l == 4'd0 || l > 4'd8) ? 4'd8 : l;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = d[7-i];
    return r;
  endfunction
endpackage

// File: rtl/spif_fifo.sv
module spif_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push, pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !out_ready) |=> !in_ready);
  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && out_ready && !in_valid) |=> (count == '0));
endmodule

// File: rtl/spif_shifter.sv
module spif_shifter
  import spif_pkg::*;
#(
  parameter int DIVW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div,
  input  logic            pol,
  input  logic            pha,
  input  fmt_t            cfg,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [7:0]      tx_data,
  output logic            rx_valid,
  output logic [7:0]      rx_data,
  output logic            busy,
  output logic            sck,
  output logic [3:0]      dq_o,
  output logic [3:0]      dq_oe,
  input  logic [3:0]      dq_i
);
  logic [DIVW-1:0] tick_cnt;
  logic [4:0]      edge_cnt, nedges;
  logic            sck_int;
  logic [7:0]      sreg, rxr, inb;
  logic [3:0]      elen;
  fmt_t            fcfg;
  logic [2:0]      lanes;
  logic            lead, smp, sft;

  function automatic logic [7:0] order_rx(input logic [7:0] raw,
                                          input logic [3:0] n, input logic lsb);
    logic [7:0] r;
    r = '0;
    if (!lsb) r = raw;
    else for (int i = 0; i < 8; i++) if (i < int'(n)) r[i] = raw[int'(n) - 1 - i];
    return r;
  endfunction

  assign lanes    = lane_cnt(fcfg.proto);
  assign lead     = ~edge_cnt[0];
  assign smp      = pha ? !lead : lead;
  assign sft      = pha ? (lead && edge_cnt != 5'd0) : !lead;
  assign tx_ready = !busy;
  assign sck      = pol ^ sck_int;

  always_comb begin
    case (lanes)
      3'd2:    begin inb = {6'b0, dq_i[1:0]}; dq_o = {2'b0, sreg[7:6]};
                     dq_oe = (busy && fcfg.dir_tx) ? 4'b0011 : 4'b0000; end
      3'd4:    begin inb = {4'b0, dq_i};      dq_o = sreg[7:4];
                     dq_oe = (busy && fcfg.dir_tx) ? 4'b1111 : 4'b0000; end
      default: begin inb = {7'b0, dq_i[1]};   dq_o = {3'b0, sreg[7]};
                     dq_oe = busy ? 4'b0001 : 4'b0000; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; tick_cnt <= '0; edge_cnt <= '0; nedges <= '0;
      sck_int <= 1'b0; sreg <= '0; rxr <= '0; elen <= 4'd8;
      fcfg <= '0; rx_valid <= 1'b0; rx_data <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!busy) begin
        tick_cnt <= '0;
        if (tx_valid) begin
          busy     <= 1'b1;
          fcfg     <= cfg;
          elen     <= eff_len(cfg.len);
          edge_cnt <= '0;
          nedges   <= {eff_len(cfg.len) >> lane_log(cfg.proto), 1'b0};
          sreg     <= cfg.lsb_first ? rev8(tx_data)
                                    : (tx_data << (4'd8 - eff_len(cfg.len)));
          rxr      <= '0;
        end
      end else if (tick_cnt < div) begin
        tick_cnt <= tick_cnt + 1'b1;
      end else begin
        tick_cnt <= '0;
        if (edge_cnt == nedges) begin
          busy     <= 1'b0;
          rx_valid <= !fcfg.dir_tx;
          rx_data  <= order_rx(rxr, elen, fcfg.lsb_first);
        end else begin
          sck_int  <= ~sck_int;
          edge_cnt <= edge_cnt + 1'b1;
          if (smp) rxr  <= (rxr << lanes) | inb;
          if (sft) sreg <= sreg << lanes;
        end
      end
    end
  end

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_int);
  // R12
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (edge_cnt <= nedges));
  // R8
  tx_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fcfg.dir_tx) |=> !rx_valid);
endmodule

// File: rtl/spif_ctrl.sv
module spif_ctrl
  import spif_pkg::*;
#(
  parameter int DIVW  = 12,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sck,
  output logic        cs_n,
  output logic [3:0]  dq_o,
  output logic [3:0]  dq_oe,
  input  logic [3:0]  dq_i,
  output logic        irq
);
  logic [DIVW-1:0] div_q;
  logic            pol_q, pha_q, held;
  cs_mode_e        csmode;
  fmt_t            fmt_q;
  logic [15:0]     txmark, rxmark;
  logic [1:0]      ie_q, ip;

  logic          tx_push, tx_room, tx_have, tx_take;
  logic [7:0]    tx_head, rx_head, sh_rx_data;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          rx_pop, rx_have, unused_rx_room, sh_rx_valid, sh_busy;
  logic [7:0]    unused_wbits;

  assign tx_push      = reg_wr && (reg_addr == A_TXD);
  assign rx_pop       = reg_rd && (reg_addr == A_RXD);
  assign unused_wbits = reg_wdata[31:24];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIVW'(3); pol_q <= 1'b0; pha_q <= 1'b0; csmode <= CS_AUTO;
      fmt_q <= '{len: 4'd8, dir_tx: 1'b0, lsb_first: 1'b0, proto: 2'd0};
      txmark <= '0; rxmark <= '0; ie_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_DIV:    div_q  <= reg_wdata[DIVW-1:0];
        A_CLKM:   {pha_q, pol_q} <= reg_wdata[1:0];
        A_CSMODE: csmode <= cs_mode_e'(reg_wdata[1:0]);
        A_FMT:    fmt_q  <= '{len: reg_wdata[19:16], dir_tx: reg_wdata[3],
                              lsb_first: reg_wdata[2], proto: reg_wdata[1:0]};
        A_TXCTL:  txmark <= reg_wdata[15:0];
        A_RXCTL:  rxmark <= reg_wdata[15:0];
        A_IE:     ie_q   <= reg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          held <= 1'b0;
    else if (sh_busy && csmode == CS_HOLD) held <= 1'b1;
    else if (!sh_busy && csmode != CS_HOLD) held <= 1'b0;
  end

  assign cs_n = !((csmode != CS_OFF) && (sh_busy || held));
  assign ip   = {(16'(rx_cnt) > rxmark), (16'(tx_cnt) < txmark)};
  assign irq  = |(ip & ie_q);

  always_comb begin
    case (reg_addr)
      A_DIV:    reg_rdata = 32'(div_q);
      A_CLKM:   reg_rdata = {30'b0, pha_q, pol_q};
      A_CSMODE: reg_rdata = {30'b0, csmode};
      A_FMT:    reg_rdata = {12'b0, fmt_q.len, 12'b0, fmt_q.dir_tx,
                             fmt_q.lsb_first, fmt_q.proto};
      A_TXD:    reg_rdata = {!tx_room, 31'b0};
      A_RXD:    reg_rdata = {!rx_have, 23'b0, rx_have ? rx_head : 8'h00};
      A_TXCTL:  reg_rdata = {16'b0, txmark};
      A_RXCTL:  reg_rdata = {16'b0, rxmark};
      A_IE:     reg_rdata = {30'b0, ie_q};
      A_IP:     reg_rdata = {30'b0, ip};
      default:  reg_rdata = '0;
    endcase
  end

  spif_fifo #(.W(8), .DEPTH(DEPTH), .CW(CW)) u_txq (
    .clk, .rst_n, .in_valid(tx_push), .in_ready(tx_room), .in_data(reg_wdata[7:0]),
    .out_valid(tx_have), .out_ready(tx_take), .out_data(tx_head), .count(tx_cnt));

  spif_fifo #(.W(8), .DEPTH(DEPTH), .CW(CW)) u_rxq (
    .clk, .rst_n, .in_valid(sh_rx_valid), .in_ready(unused_rx_room), .in_data(sh_rx_data),
    .out_valid(rx_have), .out_ready(rx_pop), .out_data(rx_head), .count(rx_cnt));

  spif_shifter #(.DIVW(DIVW)) u_shf (
    .clk, .rst_n, .div(div_q), .pol(pol_q), .pha(pha_q), .cfg(fmt_q),
    .tx_valid(tx_have), .tx_ready(tx_take), .tx_data(tx_head),
    .rx_valid(sh_rx_valid), .rx_data(sh_rx_data), .busy(sh_busy),
    .sck, .dq_o, .dq_oe, .dq_i);

  // R11
  held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && csmode == CS_HOLD) |=> held);
  // R7
  rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sh_rx_valid && !rx_pop) |=> $stable(rx_cnt));
  // R5
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csmode == CS_OFF) |-> cs_n);
endmodule

// File: tb/sim_spif_ctrl.sv
module sim_spif_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sck, cs_n, irq;
  logic [3:0] dq_o, dq_oe, dq_i;

  int tests = 0, fails = 0;
  int lanes_b = 1, nsamp = 0, cs_falls = 0, cs_rises = 0;
  bit pol_b = 0, pha_b = 0;
  logic [63:0] pat = '0, stream = '0;
  logic [7:0] mosi = '0;
  logic cs_seen = 1'b1;
  time t_last = 0, per = 0;

  always #10 clk = ~clk;

  spif_ctrl u0 (.clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
                .sck, .cs_n, .dq_o, .dq_oe, .dq_i, .irq);

  assign dq_i = (lanes_b == 1) ? {2'b0, stream[63], 1'b0} :
                (lanes_b == 2) ? {2'b0, stream[63:62]} : stream[63:60];

  // flash model: reload reply stream on select, shift after each sample edge
  always @(sck or cs_n) begin
    if (cs_n !== cs_seen) begin
      cs_seen = cs_n;
      if (cs_n == 1'b0) begin stream = pat; mosi = '0; nsamp = 0; cs_falls++; end
      else cs_rises++;
    end else if (cs_n == 1'b0 && ((sck != pol_b) == (pha_b == 1'b0))) begin
      mosi = (lanes_b == 1) ? {mosi[6:0], dq_o[0]} :
             (lanes_b == 2) ? {mosi[5:0], dq_o[1:0]} : {mosi[3:0], dq_o};
      nsamp++;
      #1 stream = stream << lanes_b;
    end
  end

  always @(posedge sck) begin per = $time - t_last; t_last = $time; end

  function automatic logic [7:0] rv(input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = d[7-i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic setfmt(input int pr, input bit lsb, input bit dtx, input bit p, input bit h, input int len);
    wr(8'h04, {30'b0, h, p});
    wr(8'h40, {12'b0, 4'(len), 12'b0, dtx, lsb, 2'(pr)});
    lanes_b = (pr == 1) ? 2 : (pr == 2) ? 4 : 1; pol_b = p; pha_b = h;
  endtask

  task automatic send(input logic [7:0] b);
    wr(8'h48, {24'b0, b}); repeat (100) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int pre;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    // R1 reset state
    chk(cs_n == 1 && sck == 0 && irq == 0, "R1 idle pins", {cs_n, sck, irq}, 3'b100);
    rd(8'h00, d); chk(d == 3, "R1 div reset", d, 3);
    rd(8'h4C, d); chk(d[31] == 1, "R7 empty flag", d, 32'h80000000);
    rd(8'h48, d); chk(d[31] == 0, "R6 not full", d, 0);
    rd(8'h74, d); chk(d == 0, "R9 ip reset", d, 0);
    // R1 SCK period at default and at div=1
    setfmt(0, 0, 1, 0, 0, 8); pat = 64'hC3; send(8'h96);
    chk(per == 160, "R1 period div3", per, 160);
    chk(mosi == 8'h96, "R4 single tx", mosi, 8'h96);
    wr(8'h00, 1); send(8'h11);
    chk(per == 80, "R1 period div1", per, 80);
    // random frames
    for (int k = 0; k < 40; k++) begin
      int pr; bit lsb, dtx, p, h; logic [7:0] b, e;
      pr = $urandom % 3; lsb = 1'($urandom); dtx = 1'($urandom);
      p = 1'($urandom); h = 1'($urandom); b = 8'($urandom);
      pat = {$urandom, $urandom};
      setfmt(pr, lsb, dtx, p, h, 8); send(b);
      chk(nsamp == 8 / lanes_b, "R2 sample count", nsamp, 8 / lanes_b);
      if (dtx || pr == 0) chk(mosi == (lsb ? rv(b) : b), "R4 tx bits", mosi, lsb ? rv(b) : b);
      rd(8'h4C, d);
      if (dtx) chk(d[31] == 1, "R8 no rx push", d, 32'h80000000);
      else begin
        e = lsb ? rv(pat[63:56]) : pat[63:56];
        chk(d == {24'b0, e}, "R3 rx byte", d, e);
      end
    end
    // R12 short frame
    setfmt(0, 0, 0, 0, 0, 4); pat = 64'hB000_0000_0000_0000; send(8'hA5);
    chk(nsamp == 4, "R12 short count", nsamp, 4);
    chk(mosi[3:0] == 4'h5, "R12 short tx", mosi[3:0], 5);
    rd(8'h4C, d); chk(d == 32'h0B, "R12 short rx", d, 32'h0B);
    // R5/R11 hold: command, echo discard, two polls on one select
    setfmt(0, 0, 0, 0, 0, 8); pat = 64'h1122_3344_5566_7788;
    wr(8'h18, 2); pre = cs_rises;
    send(8'h05); rd(8'h4C, d); chk(d == 32'h11, "R11 echo", d, 32'h11);
    send(8'h00); rd(8'h4C, d); chk(d == 32'h22, "R11 poll1", d, 32'h22);
    send(8'h00); rd(8'h4C, d); chk(d == 32'h33, "R11 poll2", d, 32'h33);
    chk(cs_rises == pre && cs_n == 0, "R5 hold kept", cs_rises - pre, 0);
    wr(8'h18, 0); repeat (3) @(negedge clk);
    chk(cs_n == 1, "R11 release", cs_n, 1);
    // R5 off mode
    wr(8'h18, 3); pre = cs_falls; send(8'h5A);
    chk(cs_falls == pre && cs_n == 1, "R5 off", cs_falls - pre, 0);
    rd(8'h4C, d); wr(8'h18, 0);
    // R6 full queue, overflow ignored, R9 tx watermark
    setfmt(0, 0, 1, 0, 0, 8); wr(8'h00, 200); pre = cs_falls;
    for (int i = 0; i < 9; i++) wr(8'h48, 32'(i));
    rd(8'h48, d); chk(d[31] == 1, "R6 full flag", d, 32'h80000000);
    wr(8'h50, 9); rd(8'h74, d); chk(d[0] == 1, "R9 tx wm set", d, 1);
    wr(8'h50, 8); rd(8'h74, d); chk(d[0] == 0, "R9 tx wm clear", d, 0);
    wr(8'h48, 32'hEE); wr(8'h00, 0); repeat (400) @(negedge clk);
    chk(cs_falls - pre == 9, "R6 overflow dropped", cs_falls - pre, 9);
    wr(8'h50, 0); wr(8'h00, 1);
    // R9/R10 rx watermark and irq
    setfmt(0, 0, 0, 0, 0, 8);
    for (int i = 0; i < 3; i++) send(8'h00);
    wr(8'h54, 2); rd(8'h74, d); chk(d[1] == 1, "R9 rx wm set", d, 2);
    wr(8'h70, 2); @(negedge clk); chk(irq == 1, "R10 irq on", irq, 1);
    wr(8'h70, 1); @(negedge clk); chk(irq == 0, "R10 irq masked", irq, 0);
    wr(8'h54, 3); rd(8'h74, d); chk(d[1] == 0, "R9 rx wm clear", d, 0);
    for (int i = 0; i < 3; i++) rd(8'h4C, d);
    rd(8'h4C, d); chk(d[31] == 1, "R7 drained", d, 32'h80000000);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule